// File: doc/BRIEF.md
# Bit count and leading-one finder

This block is a combinational bit-scan unit for an integer datapath. It takes one operand word and returns one of two scan results. The first is the number of set bits in the word. The second is the position of the most significant bit of interest.

An invert control complements the operand before either scan. The leading-one scan has two modifiers. A signed modifier searches for the highest bit whose value differs from the sign bit. A distance modifier folds the found index with `WIDTH-1`, so that it reads as a count of bits from the top. When the leading-one scan finds nothing, it returns an all-ones word. The distance modifier does not fold this value.

The block has no registers. Its result settles in the same cycle as its inputs. The operand width is a parameter and must be a power of two; the default is 32.

Top module: `bscan_unit`

## Requirements
- R1: When `inv_en` is 1, the operand is bitwise complemented before either scan runs. This applies to both values of `scan_op`.
- R2: With `scan_op` = 0 (bit count), `result` is the number of 1 bits in the possibly inverted operand, zero-extended, in the range 0 to 32.
- R3: With `scan_op` = 1 (leading one), `sign_en` = 0 and `dist_en` = 0, `result` is the index (0 to 31) of the highest set bit. Bit 0 is the least significant bit.
- R4: With `scan_op` = 1 and `sign_en` = 1, `result` is the highest bit position whose value differs from bit 31 of the possibly inverted operand.
- R5: With `scan_op` = 1 and `dist_en` = 1, a found index is XORed with 31 before it is output, so index 31 gives 0 and index 0 gives 31.
- R6: With `scan_op` = 1, `sign_en` = 0 and an effective operand of zero, `result` is 0xFFFFFFFF.
- R7: With `scan_op` = 1, `sign_en` = 1 and an effective operand of all zeros or all ones, `result` is 0xFFFFFFFF.
- R8: The no-result value 0xFFFFFFFF is output unchanged when `dist_en` = 1.
- R9: With `scan_op` = 0, `sign_en` and `dist_en` have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Operand word |
| scan_op | input | 1 | 0 = bit count, 1 = leading-one scan |
| inv_en | input | 1 | Complement the operand before scanning |
| sign_en | input | 1 | Leading-one scan searches for the first bit that differs from the sign |
| dist_en | input | 1 | Fold a found index with 31 |
| result | output | 32 | Scan result |

## Verification
The bench targets the following corner cases:

- **Zero, all-ones and single-bit operands in every mode.** A finder that returned index 0 instead of the no-result value on a zero word would be caught. So would a finder that did not treat all-ones as "no differing bit" in signed mode.
- **The distance modifier on an empty scan.** A design that folded the no-result value would return 0xFFFFFFE0 instead of 0xFFFFFFFF.
- **Inversion ahead of the signed scan.** A design that inverted after choosing the sign would report a different index.
- **Modifier bits during bit counts.** Setting `sign_en` and `dist_en` in bit-count mode exposes a count polluted by either modifier.

Random operands, biased toward long runs of equal bits, cover the remaining space.

// File: rtl/bscan_pkg.sv
// Package: shared encodings for the bit-scan unit.
// Assumes: the operand width is a power of two.
package bscan_pkg;

    // Scan selector encoding, as driven on the scan_op port.
    typedef enum logic {
        SCAN_COUNT = 1'b0,
        SCAN_LEAD  = 1'b1
    } scan_op_e;

endpackage

// File: rtl/bscan_popcount.sv
// Module: counts the set bits of a word.
// Assumes: CNTW is wide enough to hold WIDTH.
module bscan_popcount #(
    parameter int WIDTH = 32,
    parameter int CNTW  = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] word,
    output logic [CNTW-1:0]  count
);

    // Add every bit into a running total.
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNTW'(word[i]);
        end
    end

endmodule

// File: rtl/bscan_sign_fold.sv
// Module: in signed mode, XORs each bit with the sign bit. The highest set bit
// of the output is then the highest bit that differs from the sign. The output
// MSB is always 0 in signed mode. Otherwise the word passes through unchanged.
// Assumes: WIDTH >= 2.
module bscan_sign_fold #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    input  logic             sign_en,
    output logic [WIDTH-1:0] folded
);

    localparam int TOP = WIDTH - 1;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            // Flip this bit against the sign when signed mode is on.
            assign folded[g] = word[g] ^ (sign_en & word[TOP]);
        end
    endgenerate

endmodule

// File: rtl/bscan_msb_find.sv
// Module: finds the index of the highest set bit of a word.
// Assumes: when found is 0, idx carries no meaning (it is driven to 0).
module bscan_msb_find #(
    parameter int WIDTH = 32,
    parameter int IDXW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word,
    output logic             found,
    output logic [IDXW-1:0]  idx
);

    // Scan from the LSB upward; the last set bit seen wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (word[i]) begin
                found = 1'b1;
                idx   = i[IDXW-1:0];
            end
        end
    end

endmodule

// File: rtl/bscan_unit.sv
// Module: combinational bit-scan unit (top). It provides the set-bit count and
// a leading-one scan with signed and distance modifiers.
// Assumes: WIDTH is a power of two, so XOR with WIDTH-1 equals (WIDTH-1)-idx.
// No state is held, so no clock or reset is present.
module bscan_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd,
    input  logic             scan_op,
    input  logic             inv_en,
    input  logic             sign_en,
    input  logic             dist_en,
    output logic [WIDTH-1:0] result
);
    import bscan_pkg::*;

    localparam int IDXW = $clog2(WIDTH);
    localparam int CNTW = $clog2(WIDTH + 1);
    localparam logic [IDXW-1:0] IDX_TOP = IDXW'(WIDTH - 1);

    logic [WIDTH-1:0] eff_word;
    logic [WIDTH-1:0] fold_word;
    logic [CNTW-1:0]  bit_count;
    logic             lead_found;
    logic [IDXW-1:0]  lead_idx;
    logic [IDXW-1:0]  lead_out;
    scan_op_e         op_sel;

    // Apply the optional complement ahead of both scans.
    assign eff_word = inv_en ? ~opnd : opnd;
    assign op_sel   = scan_op_e'(scan_op);

    bscan_popcount #(.WIDTH(WIDTH), .CNTW(CNTW)) u_count (
        .word  (eff_word),
        .count (bit_count)
    );

    bscan_sign_fold #(.WIDTH(WIDTH)) u_fold (
        .word    (eff_word),
        .sign_en (sign_en),
        .folded  (fold_word)
    );

    bscan_msb_find #(.WIDTH(WIDTH), .IDXW(IDXW)) u_find (
        .word  (fold_word),
        .found (lead_found),
        .idx   (lead_idx)
    );

    // Fold the found index into a distance from the top when requested.
    assign lead_out = dist_en ? (lead_idx ^ IDX_TOP) : lead_idx;

    // Select the result; an empty scan yields the all-ones no-result value.
    always_comb begin
        if (op_sel == SCAN_COUNT) begin
            result = WIDTH'(bit_count);
        end else if (!lead_found) begin
            result = '1;
        end else begin
            result = WIDTH'(lead_out);
        end
    end

endmodule

// File: rtl/bscan_unit_chk.sv
// Module: assertion checker for bscan_unit, attached to it through bind.
// Assumes: combinational top, so only immediate assertions are used.
module bscan_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd,
    input logic             scan_op,
    input logic             inv_en,
    input logic             sign_en,
    input logic             dist_en,
    input logic [WIDTH-1:0] result
);
    localparam int IDXW = $clog2(WIDTH);

    logic [WIDTH-1:0] eff;
    logic [IDXW-1:0]  ridx;
    assign eff  = inv_en ? ~opnd : opnd;
    assign ridx = result[IDXW-1:0];

    // Check the port relations whenever any input changes.
    always_comb begin
        if (!scan_op) begin
            a_r2_count_range: assert (result <= WIDTH);
        end
        if (scan_op && !sign_en && eff == '0) begin
            a_r6_zero_none: assert (result == '1);
        end
        if (scan_op && sign_en && (eff == '0 || eff == '1)) begin
            a_r7_signed_none: assert (result == '1);
        end
        if (scan_op && dist_en && !sign_en && eff == '0) begin
            a_r8_none_unfolded: assert (result == '1);
        end
        if (scan_op && !sign_en && !dist_en && eff != '0) begin
            a_r3_top_set: assert (result < WIDTH && (eff >> ridx) == 1);
        end
        if (scan_op && sign_en && !dist_en && eff != '0 && eff != '1) begin
            a_r4_differs: assert (result < WIDTH && eff[ridx] != eff[WIDTH-1]);
        end
    end

endmodule

bind bscan_unit bscan_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd    (opnd),
    .scan_op (scan_op),
    .inv_en  (inv_en),
    .sign_en (sign_en),
    .dist_en (dist_en),
    .result  (result)
);

// File: tb/sim_bscan_unit.sv
module sim_bscan_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd = '0;
    logic        scan_op = 1'b0;
    logic        inv_en = 1'b0;
    logic        sign_en = 1'b0;
    logic        dist_en = 1'b0;
    logic [31:0] result;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bscan_unit #(.WIDTH(32)) u0 (
        .opnd(opnd), .scan_op(scan_op), .inv_en(inv_en),
        .sign_en(sign_en), .dist_en(dist_en), .result(result)
    );

    function automatic logic [31:0] exp_val(input logic [31:0] v, input logic op,
                                            input logic inv, input logic sg, input logic ds);
        logic [31:0] w;
        int          pos;
        int          cnt;
        w = inv ? ~v : v;
        if (!op) begin
            cnt = 0;
            for (int i = 0; i < 32; i++) cnt += int'(w[i]);
            return 32'(cnt);
        end
        pos = -1;
        for (int i = 31; i >= 0; i--) begin
            if (pos < 0) begin
                if (sg) begin
                    if (i < 31 && w[i] != w[31]) pos = i;
                end else if (w[i]) begin
                    pos = i;
                end
            end
        end
        if (pos < 0) return 32'hFFFF_FFFF;
        return ds ? 32'(31 - pos) : 32'(pos);
    endfunction

    task automatic check(input string req, input logic [31:0] v, input logic op,
                         input logic inv, input logic sg, input logic ds);
        logic [31:0] e;
        @(negedge clk);
        opnd = v; scan_op = op; inv_en = inv; sign_en = sg; dist_en = ds;
        #1;
        e = exp_val(v, op, inv, sg, ds);
        total++;
        if (result !== e) begin
            bad++;
            $display("FAIL %s opnd=%h op=%0d inv=%0d sg=%0d ds=%0d actual=%h expected=%h",
                     req, v, op, inv, sg, ds, result, e);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: zero operand, count mode
        check("R2", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2", 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1", 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R1", 32'h0000_00F0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R3", 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3", 32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3", 32'h0001_2345, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", 32'hFFFF_0000, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R4", 32'h0001_0000, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R4", 32'hFFFF_0000, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R5", 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R5", 32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R5", 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R6", 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R7", 32'h0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R7", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R8", 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R8", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R9", 32'h0F0F_0001, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R9", 32'hF000_0000, 1'b0, 1'b1, 1'b1, 1'b1);
        r = $urandom(32'd4099);
        for (int k = 0; k < 3000; k++) begin
            r = $urandom;
            // Bias some operands toward long runs of equal bits.
            case (k % 4)
                1: r = r >> (r[4:0]);
                2: r = ~(r >> (r[9:5]));
                default: ;
            endcase
            check("R2/R3/R4/R5 random", r, k[0], k[1], k[2], k[3]);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule